// File: doc/BRIEF.md
# Command and Receive FIFO Pair

This block holds the two queues that sit between a serial bus controller's register file and its bus engine. The command queue is filled from the register side with 11-bit command words and drained by the engine. The receive queue is filled by the engine with data bytes and drained from the register side. Each queue holds 64 entries and preserves arrival order.

A control word selects a flush for each queue on its own and sets two 6-bit watermarks. A status word reports empty and full state and four sticky error flags, one for each illegal access: a push onto a full queue, or a pop from an empty one. Three level outputs tell an interrupt unit that an error is pending, that the receive queue has reached its watermark, or that the command queue has drained down to its watermark. Interrupt masking and the bus engine live elsewhere.

Top module: `cmd_rx_fifo_pair`

## Requirements
- R1: Each queue holds 64 entries and returns them in the order written. The command queue carries 11-bit words and the receive queue carries 8-bit bytes.
- R2: The control word reads back as {txMark[13:8], rxMark[7:2], txFlush[1], rxFlush[0]}. A write replaces it. After reset it reads 0x1F0, which is txMark=1, rxMark=60 and both flush bits clear.
- R3: The status word has rxReadErr at bit 0, rxWriteErr at bit 1, rxEmpty at bit 3, txReadErr at bit 6, txWriteErr at bit 7 and txFull at bit 11. All other bits read 0. After reset it reads 0x008.
- R4: A push onto a full queue is dropped, and the queue keeps its 64 entries. The drop sets that queue's write-error flag: status bit 1 for the receive queue and bit 7 for the command queue.
- R5: A pop from an empty queue returns zero on its data output. It sets that queue's read-error flag: status bit 0 for the receive queue and bit 6 for the command queue.
- R6: An error flag stays set until its own queue is flushed. evtFifoErr is high while any of the four flags is set.
- R7: Control bit 0 flushes the receive queue and bit 1 flushes the command queue. The queue is empty, and its error flags are clear, from the cycle after the bit is first seen set. While the bit stays set, pushes to that queue are ignored without raising an error. A flush of one queue leaves the other queue's content untouched.
- R8: evtRxFull is high exactly when the receive level is greater than or equal to rxMark.
- R9: evtTxEmpty is high exactly when the command level is less than or equal to txMark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the control word |
| cfgWrData | input | 14 | Control word write value |
| cfgRdData | output | 14 | Control word read value |
| statusWord | output | 12 | Status flags |
| cmdWrEn | input | 1 | Register-side push into the command queue |
| cmdWrData | input | 11 | Command word to push |
| rxRdEn | input | 1 | Register-side pop from the receive queue |
| rxRdData | output | 8 | Head of the receive queue, zero when empty |
| engCmdPop | input | 1 | Engine-side pop from the command queue |
| engCmdData | output | 11 | Head of the command queue, zero when empty |
| engRxPush | input | 1 | Engine-side push into the receive queue |
| engRxData | input | 8 | Byte to push into the receive queue |
| evtFifoErr | output | 1 | Level event: an error flag is set |
| evtRxFull | output | 1 | Level event: receive level at or above rxMark |
| evtTxEmpty | output | 1 | Level event: command level at or below txMark |

## Verification
The bench fills each queue to exactly 64 entries and offers one more. A design with an off-by-one full test would either accept and lose data, or refuse the 64th entry; the in-order drain through the scoreboard exposes both. It pops past empty, expecting zero data and the read flag. A design that returned stale storage, or missed the flag, fails there. It checks that flags survive later traffic and clear only on a flush of their own queue, and that pushes during a held flush vanish without an error. Watermark events are probed on both sides of each boundary after a reprogramming, which catches a strict comparison where an inclusive one is required.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

  // Strobes issued by the control unit to the storage datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;

  // Status word layout; a register-file neighbour decodes these positions
  localparam int STATUS_W    = 12;
  localparam int ST_RX_RDERR = 0;
  localparam int ST_RX_WRERR = 1;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_TX_RDERR = 6;
  localparam int ST_TX_WRERR = 7;
  localparam int ST_TX_FULL  = 11;

endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               pushData,
  input  logic                       pop,
  output logic [W-1:0]               headData,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign headData = empty ? '0 : mem[rdPtr];

endmodule

// File: rtl/fifo_pair_dp.sv
module fifo_pair_dp
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CMD_W  = 11,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobes_t           strb,
  input  logic [CMD_W-1:0]       cmdWrData,
  input  logic [DATA_W-1:0]      engRxData,
  output logic [CMD_W-1:0]       engCmdData,
  output logic [DATA_W-1:0]      rxRdData,
  output logic [$clog2(DEPTH):0] txLevel,
  output logic [$clog2(DEPTH):0] rxLevel,
  output logic                   txEmpty,
  output logic                   txFull,
  output logic                   rxEmpty,
  output logic                   rxFull
);

  fifo_store #(.W(CMD_W), .DEPTH(DEPTH)) txStore (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush),
    .push(strb.txPush), .pushData(cmdWrData), .pop(strb.txPop),
    .headData(engCmdData), .level(txLevel), .empty(txEmpty), .full(txFull)
  );

  fifo_store #(.W(DATA_W), .DEPTH(DEPTH)) rxStore (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush),
    .push(strb.rxPush), .pushData(engRxData), .pop(strb.rxPop),
    .headData(rxRdData), .level(rxLevel), .empty(rxEmpty), .full(rxFull)
  );

endmodule

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int THR_W      = 6,
  parameter int RX_THR_RST = 60,
  parameter int TX_THR_RST = 1,
  localparam int CFG_W     = 2 + 2 * THR_W,
  localparam int LW        = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [CFG_W-1:0]    cfgWrData,
  input  logic                cmdWrEn,
  input  logic                rxRdEn,
  input  logic                engCmdPop,
  input  logic                engRxPush,
  input  logic [LW-1:0]       txLevel,
  input  logic [LW-1:0]       rxLevel,
  input  logic                txEmpty,
  input  logic                txFull,
  input  logic                rxEmpty,
  input  logic                rxFull,
  output fifoStrobes_t        strb,
  output logic [CFG_W-1:0]    cfgRdData,
  output logic [STATUS_W-1:0] statusWord,
  output logic                evtFifoErr,
  output logic                evtRxFull,
  output logic                evtTxEmpty
);

  logic             flushRx, flushTx;
  logic [THR_W-1:0] rxMark, txMark;
  logic             rxRdErr, rxWrErr, txRdErr, txWrErr;

  // Control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushRx <= 1'b0;
      flushTx <= 1'b0;
      rxMark  <= THR_W'(RX_THR_RST);
      txMark  <= THR_W'(TX_THR_RST);
    end else if (cfgWrEn) begin
      flushRx <= cfgWrData[0];
      flushTx <= cfgWrData[1];
      rxMark  <= cfgWrData[2 +: THR_W];
      txMark  <= cfgWrData[2 + THR_W +: THR_W];
    end
  end

  assign cfgRdData = {txMark, rxMark, flushTx, flushRx};

  // Qualified strobes: no access to a queue under flush
  always_comb begin
    strb.txFlush = flushTx;
    strb.rxFlush = flushRx;
    strb.txPush  = cmdWrEn   && !txFull  && !flushTx;
    strb.txPop   = engCmdPop && !txEmpty && !flushTx;
    strb.rxPush  = engRxPush && !rxFull  && !flushRx;
    strb.rxPop   = rxRdEn    && !rxEmpty && !flushRx;
  end

  // Sticky error flags, cleared only by their own queue's flush
  always_ff @(posedge clk) begin
    if (!rstN || flushTx) begin
      txRdErr <= 1'b0;
      txWrErr <= 1'b0;
    end else begin
      if (cmdWrEn && txFull)    txWrErr <= 1'b1;
      if (engCmdPop && txEmpty) txRdErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushRx) begin
      rxRdErr <= 1'b0;
      rxWrErr <= 1'b0;
    end else begin
      if (engRxPush && rxFull) rxWrErr <= 1'b1;
      if (rxRdEn && rxEmpty)   rxRdErr <= 1'b1;
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[ST_RX_RDERR] = rxRdErr;
    statusWord[ST_RX_WRERR] = rxWrErr;
    statusWord[ST_RX_EMPTY] = rxEmpty;
    statusWord[ST_TX_RDERR] = txRdErr;
    statusWord[ST_TX_WRERR] = txWrErr;
    statusWord[ST_TX_FULL]  = txFull;
  end

  assign evtFifoErr = rxRdErr | rxWrErr | txRdErr | txWrErr;
  assign evtRxFull  = (rxLevel >= LW'(rxMark));
  assign evtTxEmpty = (txLevel <= LW'(txMark));

endmodule

// File: rtl/cmd_rx_fifo_pair.sv
module cmd_rx_fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int CMD_W      = 11,
  parameter int DATA_W     = 8,
  parameter int THR_W      = 6,
  parameter int RX_THR_RST = 60,
  parameter int TX_THR_RST = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [2*THR_W+1:0]  cfgWrData,
  output logic [2*THR_W+1:0]  cfgRdData,
  output logic [11:0]         statusWord,
  input  logic                cmdWrEn,
  input  logic [CMD_W-1:0]    cmdWrData,
  input  logic                rxRdEn,
  output logic [DATA_W-1:0]   rxRdData,
  input  logic                engCmdPop,
  output logic [CMD_W-1:0]    engCmdData,
  input  logic                engRxPush,
  input  logic [DATA_W-1:0]   engRxData,
  output logic                evtFifoErr,
  output logic                evtRxFull,
  output logic                evtTxEmpty
);
  localparam int LW = $clog2(DEPTH) + 1;

  fifoStrobes_t strb;
  logic [LW-1:0] txLevel, rxLevel;
  logic          txEmpty, txFull, rxEmpty, rxFull;

  fifo_pair_ctrl #(
    .DEPTH(DEPTH), .THR_W(THR_W),
    .RX_THR_RST(RX_THR_RST), .TX_THR_RST(TX_THR_RST)
  ) ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cmdWrEn(cmdWrEn), .rxRdEn(rxRdEn), .engCmdPop(engCmdPop),
    .engRxPush(engRxPush), .txLevel(txLevel), .rxLevel(rxLevel),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .strb(strb), .cfgRdData(cfgRdData), .statusWord(statusWord),
    .evtFifoErr(evtFifoErr), .evtRxFull(evtRxFull), .evtTxEmpty(evtTxEmpty)
  );

  fifo_pair_dp #(.DEPTH(DEPTH), .CMD_W(CMD_W), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cmdWrData(cmdWrData), .engRxData(engRxData),
    .engCmdData(engCmdData), .rxRdData(rxRdData),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull)
  );

endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7,
  parameter int CW    = 14,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] cfgRdData,
  input logic [11:0]   statusWord,
  input logic          cmdWrEn,
  input logic          rxRdEn,
  input logic [DW-1:0] rxRdData,
  input logic          engRxPush,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel
);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LW'(DEPTH)) && (rxLevel <= LW'(DEPTH)));

  // R4
  tx_overflow_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn && statusWord[11] && !cfgRdData[1] |=> statusWord[7]);

  // R4
  rx_overflow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    engRxPush && (rxLevel == LW'(DEPTH)) && !cfgRdData[0] |=> (rxLevel == LW'(DEPTH)) && statusWord[1]);

  // R5
  rx_empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxRdEn && statusWord[3] |-> rxRdData == '0);

  // R6
  tx_wrerr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[7] && !cfgRdData[1] |=> statusWord[7]);

  // R6
  rx_rderr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] && !cfgRdData[0] |=> statusWord[0]);

  // R7
  rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[0] |=> statusWord[3] && !statusWord[0] && !statusWord[1]);

  // R7
  tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[1] |=> (txLevel == '0) && !statusWord[6] && !statusWord[7]);

endmodule

bind cmd_rx_fifo_pair fifo_pair_chk #(
  .DEPTH(DEPTH), .LW($clog2(DEPTH) + 1), .CW(2 * THR_W + 2), .DW(DATA_W)
) chk (
  .clk(clk), .rstN(rstN), .cfgRdData(cfgRdData), .statusWord(statusWord),
  .cmdWrEn(cmdWrEn), .rxRdEn(rxRdEn), .rxRdData(rxRdData),
  .engRxPush(engRxPush), .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/tb_cmd_rx_fifo_pair.sv
`timescale 1ns/1ps
module tb_cmd_rx_fifo_pair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [13:0] cfgWrData = '0;
  logic [13:0] cfgRdData;
  logic [11:0] statusWord;
  logic        cmdWrEn = 1'b0;
  logic [10:0] cmdWrData = '0;
  logic        rxRdEn = 1'b0;
  logic [7:0]  rxRdData;
  logic        engCmdPop = 1'b0;
  logic [10:0] engCmdData;
  logic        engRxPush = 1'b0;
  logic [7:0]  engRxData = '0;
  logic        evtFifoErr, evtRxFull, evtTxEmpty;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int rxQ[$];
  int cmdQ[$];

  always #2 clk = ~clk;

  cmd_rx_fifo_pair dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Scoreboard monitor: compares popped data against the expected queues
  always @(negedge clk) begin
    int expv;
    #1;
    if (rxRdEn) begin
      expv = (rxQ.size() != 0) ? rxQ.pop_front() : 0;
      check(rxRdData == 8'(expv), "R1/R5 rx pop data", rxRdData, expv);
    end
    if (engCmdPop) begin
      expv = (cmdQ.size() != 0) ? cmdQ.pop_front() : 0;
      check(engCmdData == 11'(expv), "R1/R5 cmd pop data", engCmdData, expv);
    end
  end

  task automatic cfgWrite(input logic [13:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(posedge clk); #1 cfgWrEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d, input bit accept);
    @(negedge clk); engRxPush = 1'b1; engRxData = d;
    if (accept) rxQ.push_back(d);
    @(posedge clk); #1 engRxPush = 1'b0;
  endtask

  task automatic pushCmd(input logic [10:0] d, input bit accept);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrData = d;
    if (accept) cmdQ.push_back(d);
    @(posedge clk); #1 cmdWrEn = 1'b0;
  endtask

  task automatic readRx();
    @(negedge clk); rxRdEn = 1'b1;
    @(posedge clk); #1 rxRdEn = 1'b0;
  endtask

  task automatic popCmd();
    @(negedge clk); engCmdPop = 1'b1;
    @(posedge clk); #1 engCmdPop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R2, R3 reset state
    check(cfgRdData == 14'h1F0, "R2 control reset", cfgRdData, 14'h1F0);
    check(statusWord == 12'h008, "R3 status reset", statusWord, 12'h008);
    check(evtTxEmpty && !evtRxFull && !evtFifoErr, "R9 reset events",
          {evtFifoErr, evtRxFull, evtTxEmpty}, 3'b001);

    // R1 short command traffic
    pushCmd(11'h5A5, 1); pushCmd(11'h100, 1); pushCmd(11'h0FF, 1);
    check(!evtTxEmpty, "R9 level 3 above mark 1", evtTxEmpty, 0);
    popCmd(); popCmd(); popCmd();
    check(evtTxEmpty, "R9 drained", evtTxEmpty, 1);

    // R1, R8 fill the receive queue
    for (int i = 0; i < 64; i++) begin
      pushRx(8'(i * 7 + 3), 1);
      if (i == 58) check(!evtRxFull, "R8 level 59 below mark", evtRxFull, 0);
      if (i == 59) check(evtRxFull, "R8 level 60 at mark", evtRxFull, 1);
    end
    check(statusWord == 12'h000, "R3 rx not empty", statusWord, 12'h000);
    // R4 overflow
    pushRx(8'hEE, 0);
    check(statusWord == 12'h002, "R4 rx write error", statusWord, 12'h002);
    check(evtFifoErr, "R6 error event", evtFifoErr, 1);
    for (int i = 0; i < 64; i++) readRx();
    // R5 underflow
    readRx();
    check(statusWord == 12'h00B, "R5 rx read error", statusWord, 12'h00B);
    pushCmd(11'h001, 1); popCmd();
    check(statusWord == 12'h00B, "R6 rx flags sticky", statusWord, 12'h00B);

    // R7 flush receive queue
    pushRx(8'h11, 0);
    cfgWrite(14'h1F1);
    @(posedge clk); #1;
    check(statusWord == 12'h008, "R7 rx flush clears", statusWord, 12'h008);
    check(!evtFifoErr, "R6 flush clears event", evtFifoErr, 0);
    pushRx(8'h22, 0);
    check(statusWord == 12'h008, "R7 push ignored in flush", statusWord, 12'h008);
    cfgWrite(14'h1F0);
    readRx();
    check(statusWord == 12'h009, "R7 queue held empty", statusWord, 12'h009);
    cfgWrite(14'h1F1); cfgWrite(14'h1F0);

    // R4 command overflow
    for (int i = 0; i < 64; i++) pushCmd(11'(i * 29 + 5), 1);
    pushCmd(11'h7FF, 0);
    check(statusWord == 12'h888, "R4 tx full and write error", statusWord, 12'h888);
    for (int i = 0; i < 62; i++) popCmd();
    check(!evtTxEmpty, "R9 level 2 above mark", evtTxEmpty, 0);
    popCmd();
    check(evtTxEmpty, "R9 level 1 at mark", evtTxEmpty, 1);
    popCmd();
    popCmd();
    check(statusWord == 12'h0C8, "R5 tx read error", statusWord, 12'h0C8);

    // R7 independence: rx content survives a command flush
    pushRx(8'hA1, 1); pushRx(8'hB2, 1);
    cfgWrite(14'h1F2);
    @(posedge clk); #1;
    check(statusWord == 12'h000, "R7 tx flush clears its flags only", statusWord, 12'h000);
    cfgWrite(14'h1F0);
    readRx(); readRx();
    check(statusWord == 12'h008, "R7 rx drained after tx flush", statusWord, 12'h008);

    // R8, R9 reprogrammed marks: tx=3, rx=2
    cfgWrite(14'h308);
    check(cfgRdData == 14'h308, "R2 control readback", cfgRdData, 14'h308);
    pushRx(8'h31, 1);
    check(!evtRxFull, "R8 level 1 below mark 2", evtRxFull, 0);
    pushRx(8'h32, 1);
    check(evtRxFull, "R8 level 2 at mark 2", evtRxFull, 1);
    pushCmd(11'h011, 1); pushCmd(11'h022, 1); pushCmd(11'h033, 1);
    check(evtTxEmpty, "R9 level 3 at mark 3", evtTxEmpty, 1);
    pushCmd(11'h044, 1);
    check(!evtTxEmpty, "R9 level 4 above mark 3", evtTxEmpty, 0);
    readRx(); readRx();
    for (int i = 0; i < 4; i++) popCmd();
    check(rxQ.size() == 0 && cmdQ.size() == 0, "R1 scoreboard drained",
          rxQ.size() + cmdQ.size(), 0);
    check(statusWord == 12'h008, "R3 final status", statusWord, 12'h008);

    done = 1;
    summary();
  end
endmodule